// File: doc/BRIEF.md
# Reset Cause Collector

This block gathers every reset request in the chip into a single synchronous chip reset and keeps an 8-bit record of what caused it. It has six request inputs: the power-on detector, the brownout detector, the external reset pin, the watchdog timeout, a software reset control bit and a serial-line break detector. The brownout detector also has an interrupt input that sets a flag without causing a reset. Three of the requests (pin, watchdog and break) pass only while their configuration enable input is 1.

Power-on detect is the block's own synchronous reset. Every other request passes through a two-flop synchronizer. Any request that passes its gate starts or restarts a fixed-length chip reset pulse. The cause flags live in a status register on a small read/write bus. A written 0 clears a flag. Power-on and watchdog resets force the flags to a fixed pattern. Every other source adds its own flag and leaves the flags already set unchanged. A second register at address 1 holds the software reset control bit. That bit clears itself when the chip reset it caused is released.

Top module: `reset_cause_hub`

## Requirements
- R1: Reading address 0 returns the status register one clock after the address is presented. Its bits are: 0 pin, 1 software, 2 watchdog, 3 break, 4 power-on, 5 brownout, 6 brownout interrupt, and bit 7 always reads 0.
- R2: While `por_i` is high, `chip_rst_o` is 1, the status register holds 0x30 (power-on and brownout flags only) and the software control bit is 0.
- R3: After the last clock edge at which a request was seen (including `por_i`), `chip_rst_o` stays 1 for 15 more edges and falls on the 16th edge.
- R4: A watchdog timeout with `wdt_en_i`=1 resets the chip and sets the status register to exactly 0x30. With `wdt_en_i`=0 it does nothing.
- R5: A reset from pin, break, software or brownout sets that source's flag. Flags set earlier stay set.
- R6: Writing address 0 clears each flag whose written bit is 0. A flag whose written bit is 1 is unchanged.
- R7: The pin resets the chip and sets bit 0 only while `ext_en_i`=1. If the pin is still held when power-on ends, bit 0 is set alongside 0x30.
- R8: A break resets the chip and sets bit 3 only while `brk_en_i`=1. With the enable at 0 it does nothing.
- R9: Writing 1 to bit 0 of address 1 resets the chip, sets bit 1 and reads back 1 at address 1. The control bit reads 0 once the chip reset is released.
- R10: A brownout always resets the chip and sets bit 5.
- R11: A brownout interrupt sets bit 6 and does not assert `chip_rst_o`.
- R12: A request input that rises before clock edge k asserts `chip_rst_o` after edge k+2 (two synchronizer flops, then the pulse register), and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_i | input | 1 | Power-on detect, synchronous active-high reset of the block |
| bod_i | input | 1 | Brownout detect request level |
| bod_irq_i | input | 1 | Brownout interrupt event level |
| ext_rst_i | input | 1 | External reset pin request, active high |
| ext_en_i | input | 1 | Configuration enable for the pin request |
| wdt_to_i | input | 1 | Watchdog timeout request |
| wdt_en_i | input | 1 | Configuration enable for the watchdog request |
| brk_i | input | 1 | Serial break detected |
| brk_en_i | input | 1 | Enable for break-caused reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register address (0 status, 1 control) |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Registered read data |
| chip_rst_o | output | 1 | Synchronous chip reset output |

## Verification
The assertions assume that the enable inputs are quasi-static configuration levels. They are changed only while no request of the same source is in flight in the synchronizer. The assertions also assume that `por_i` is already synchronous to `clk`. The bench changes enables only while the matching request input has been low for several cycles. It drives every input on the falling edge, and it raises and drops `por_i` on falling edges, so each edge sees one stable value. Request pulses last at least one full clock, so the synchronizer always catches them.

// File: rtl/reset_hub_pkg.sv
`timescale 1ns/1ps
package reset_hub_pkg;
  localparam int FLAG_W = 8;

  localparam int FB_EXT   = 0;
  localparam int FB_SW    = 1;
  localparam int FB_WDT   = 2;
  localparam int FB_BRK   = 3;
  localparam int FB_POR   = 4;
  localparam int FB_BOD   = 5;
  localparam int FB_BOIRQ = 6;

  localparam logic [FLAG_W-1:0] POR_FLAGS  = FLAG_W'((1 << FB_POR) | (1 << FB_BOD));
  localparam logic [FLAG_W-1:0] VALID_MASK = FLAG_W'(8'h7F);

  localparam int SRC_EXT   = 0;
  localparam int SRC_WDT   = 1;
  localparam int SRC_BRK   = 2;
  localparam int SRC_BOD   = 3;
  localparam int SRC_BOIRQ = 4;
  localparam int NSRC      = 5;

  localparam int STATUS_ADDR = 0;
  localparam int CTRL_ADDR   = 1;
  localparam int SW_CTRL_BIT = 0;

  typedef struct packed {
    logic wdt;
    logic ext;
    logic sw;
    logic brk;
    logic bod;
    logic boirq;
  } req_t;
endpackage

// File: rtl/rh_sync.sv
`timescale 1ns/1ps
module rh_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[s] <= '0;
      else     stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/rh_stretch.sv
`timescale 1ns/1ps
module rh_stretch #(
  parameter int PULSE_LEN = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic trig,
  output logic active,
  output logic release_o
);
  localparam int CNT_W = (PULSE_LEN > 2) ? $clog2(PULSE_LEN) : 1;
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(PULSE_LEN - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || trig) begin
      active <= 1'b1;
      cnt    <= LOAD;
    end else if (active) begin
      if (cnt == '0) active <= 1'b0;
      else           cnt    <= cnt - 1'b1;
    end
  end

  assign release_o = active && (cnt == '0) && !trig && !rst;
endmodule

// File: rtl/rh_flags.sv
`timescale 1ns/1ps
module rh_flags
  import reset_hub_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  req_t              req,
  input  logic              wr_clr,
  input  logic [FLAG_W-1:0] wdata,
  output logic [FLAG_W-1:0] flags_o
);
  logic [FLAG_W-1:0] set_m;
  logic [FLAG_W-1:0] clr_m;

  always_comb begin
    set_m           = '0;
    set_m[FB_EXT]   = req.ext;
    set_m[FB_SW]    = req.sw;
    set_m[FB_BRK]   = req.brk;
    set_m[FB_BOD]   = req.bod;
    set_m[FB_BOIRQ] = req.boirq;
    clr_m           = wr_clr ? ~wdata : '0;
  end

  always_ff @(posedge clk) begin
    if (rst || req.wdt) flags_o <= POR_FLAGS;
    else                flags_o <= ((flags_o & ~clr_m) | set_m) & VALID_MASK;
  end
endmodule

// File: rtl/rh_ctrl.sv
`timescale 1ns/1ps
module rh_ctrl
  import reset_hub_pkg::*;
#(
  parameter int ADDR_W = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wbit,
  input  logic [FLAG_W-1:0] flags,
  input  logic              release_i,
  output logic              sw_fire,
  output logic              status_wr,
  output logic              sw_bit,
  output logic [FLAG_W-1:0] rdata
);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STATUS_ADDR);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_ADDR);

  assign sw_fire   = wr && (addr == A_CTRL) && wbit;
  assign status_wr = wr && (addr == A_STAT);

  always_ff @(posedge clk) begin
    if (rst)            sw_bit <= 1'b0;
    else if (sw_fire)   sw_bit <= 1'b1;
    else if (release_i) sw_bit <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (addr == A_STAT)      rdata <= flags;
    else if (addr == A_CTRL) rdata <= {{(FLAG_W-1){1'b0}}, sw_bit};
    else                     rdata <= '0;
  end
endmodule

// File: rtl/reset_cause_hub.sv
`timescale 1ns/1ps
module reset_cause_hub
  import reset_hub_pkg::*;
#(
  parameter int PULSE_LEN   = 16,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 1
) (
  input  logic              clk,
  input  logic              por_i,
  input  logic              bod_i,
  input  logic              bod_irq_i,
  input  logic              ext_rst_i,
  input  logic              ext_en_i,
  input  logic              wdt_to_i,
  input  logic              wdt_en_i,
  input  logic              brk_i,
  input  logic              brk_en_i,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              chip_rst_o
);
  logic [NSRC-1:0]   src_raw;
  logic [NSRC-1:0]   src_sync;
  req_t              req;
  logic              trig;
  logic              rel;
  logic              sw_fire;
  logic              status_wr;
  logic              sw_bit;
  logic [FLAG_W-1:0] flags_q;

  always_comb begin
    src_raw            = '0;
    src_raw[SRC_EXT]   = ext_rst_i;
    src_raw[SRC_WDT]   = wdt_to_i;
    src_raw[SRC_BRK]   = brk_i;
    src_raw[SRC_BOD]   = bod_i;
    src_raw[SRC_BOIRQ] = bod_irq_i;
  end

  rh_sync #(.W(NSRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (por_i),
    .d   (src_raw),
    .q   (src_sync)
  );

  always_comb begin
    req.ext   = src_sync[SRC_EXT] && ext_en_i;
    req.wdt   = src_sync[SRC_WDT] && wdt_en_i;
    req.brk   = src_sync[SRC_BRK] && brk_en_i;
    req.bod   = src_sync[SRC_BOD];
    req.boirq = src_sync[SRC_BOIRQ];
    req.sw    = sw_fire;
    trig      = req.ext || req.wdt || req.brk || req.bod || req.sw;
  end

  rh_stretch #(.PULSE_LEN(PULSE_LEN)) u_stretch (
    .clk       (clk),
    .rst       (por_i),
    .trig      (trig),
    .active    (chip_rst_o),
    .release_o (rel)
  );

  rh_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk       (clk),
    .rst       (por_i),
    .wr        (bus_wr),
    .addr      (bus_addr),
    .wbit      (bus_wdata[SW_CTRL_BIT]),
    .flags     (flags_q),
    .release_i (rel),
    .sw_fire   (sw_fire),
    .status_wr (status_wr),
    .sw_bit    (sw_bit),
    .rdata     (bus_rdata)
  );

  rh_flags u_flags (
    .clk     (clk),
    .rst     (por_i),
    .req     (req),
    .wr_clr  (status_wr),
    .wdata   (bus_wdata),
    .flags_o (flags_q)
  );
endmodule

// File: rtl/rh_checker.sv
`timescale 1ns/1ps
module rh_checker
  import reset_hub_pkg::*;
#(
  parameter int ADDR_W = 1
) (
  input logic              clk,
  input logic              por_i,
  input logic              ext_en_i,
  input logic              wdt_en_i,
  input logic              brk_en_i,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [7:0]        bus_wdata,
  input logic              chip_rst_o,
  input logic [NSRC-1:0]   sync_q,
  input logic [FLAG_W-1:0] flags,
  input logic              sw_bit
);
  logic wdt_req;
  logic sw_wr;
  logic stat_wr;
  logic any_trig;

  assign wdt_req  = sync_q[SRC_WDT] && wdt_en_i;
  assign sw_wr    = bus_wr && (bus_addr == ADDR_W'(CTRL_ADDR)) && bus_wdata[SW_CTRL_BIT];
  assign stat_wr  = bus_wr && (bus_addr == ADDR_W'(STATUS_ADDR));
  assign any_trig = wdt_req || sw_wr || sync_q[SRC_BOD]
                  || (sync_q[SRC_EXT] && ext_en_i) || (sync_q[SRC_BRK] && brk_en_i);

  AST_POR_PATTERN: assert property (@(posedge clk) disable iff (por_i)
    $fell(por_i) |-> (flags == POR_FLAGS) && chip_rst_o && !sw_bit); // R2

  AST_WDT_PATTERN: assert property (@(posedge clk) disable iff (por_i)
    wdt_req |=> (flags == POR_FLAGS)); // R4

  AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (por_i)
    (!wdt_req && !stat_wr) |=> ((flags & $past(flags)) == $past(flags))); // R5

  AST_WRITE_ONE_KEEPS: assert property (@(posedge clk) disable iff (por_i)
    (stat_wr && !wdt_req) |=>
      ((flags & $past(flags) & $past(bus_wdata)) == ($past(flags) & $past(bus_wdata)))); // R6

  AST_SW_SETS_FLAG: assert property (@(posedge clk) disable iff (por_i)
    (sw_wr && !wdt_req) |=> (flags[FB_SW] && chip_rst_o)); // R9

  AST_SWBIT_CLEARS: assert property (@(posedge clk) disable iff (por_i)
    $fell(chip_rst_o) |-> !sw_bit); // R9

  AST_TRIG_HOLDS_RST: assert property (@(posedge clk) disable iff (por_i)
    any_trig |=> chip_rst_o); // R3

  AST_RISE_HAS_CAUSE: assert property (@(posedge clk) disable iff (por_i)
    $rose(chip_rst_o) |-> $past(any_trig)); // R12

  AST_BOIRQ_NO_RESET: assert property (@(posedge clk) disable iff (por_i)
    (!chip_rst_o && !any_trig) |=> !chip_rst_o); // R11
endmodule

bind reset_cause_hub rh_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .por_i      (por_i),
  .ext_en_i   (ext_en_i),
  .wdt_en_i   (wdt_en_i),
  .brk_en_i   (brk_en_i),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .chip_rst_o (chip_rst_o),
  .sync_q     (src_sync),
  .flags      (flags_q),
  .sw_bit     (sw_bit)
);

// File: tb/sim_reset_cause_hub.sv
`timescale 1ns/1ps
module sim_reset_cause_hub;
  logic       clk = 1'b0;
  logic       por = 1'b1;
  logic       bod = 1'b0, boirq = 1'b0, ext = 1'b0, ext_en = 1'b0;
  logic       wdt = 1'b0, wdt_en = 1'b0, brk = 1'b0, brk_en = 1'b0;
  logic       bus_wr = 1'b0;
  logic [0:0] bus_addr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       chip_rst;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  logic [7:0] exp_q [$];
  string      tag_q [$];
  logic       rd_req  = 1'b0;
  logic       rd_seen = 1'b0;

  always #5 clk = ~clk;

  reset_cause_hub u0 (
    .clk(clk), .por_i(por), .bod_i(bod), .bod_irq_i(boirq),
    .ext_rst_i(ext), .ext_en_i(ext_en), .wdt_to_i(wdt), .wdt_en_i(wdt_en),
    .brk_i(brk), .brk_en_i(brk_en), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .chip_rst_o(chip_rst)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_rst(input logic exp, input string req);
    chk(chip_rst === exp, req, chip_rst, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input logic a, input logic [7:0] exp, input string req);
    @(negedge clk);
    bus_addr = a;
    exp_q.push_back(exp);
    tag_q.push_back(req);
    rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = 8'h00;
  endtask

  always @(posedge clk) rd_seen <= rd_req;

  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R1 empty-queue", bus_rdata, 0);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(bus_rdata === e, t, bus_rdata, e);
      end
    end
  end

  initial begin
    #50000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R3 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    // R2: power-on state
    idle(3);
    chk_rst(1'b1, "R2");
    rd(1'b0, 8'h30, "R2");
    rd(1'b1, 8'h00, "R2");
    por = 1'b0;
    // R3: 15 more edges high, falls on the 16th
    for (int i = 0; i < 15; i++) begin
      @(negedge clk);
      chk_rst(1'b1, "R3");
    end
    @(negedge clk);
    chk_rst(1'b0, "R3");
    rd(1'b0, 8'h30, "R1");

    // R6: write ones keep, zeros clear
    wr(1'b0, 8'hFF);
    rd(1'b0, 8'h30, "R6");
    wr(1'b0, 8'hEF);
    rd(1'b0, 8'h20, "R6");
    wr(1'b0, 8'h00);
    rd(1'b0, 8'h00, "R6");

    // R11: brownout interrupt, no reset
    @(negedge clk); boirq = 1'b1;
    @(negedge clk); boirq = 1'b0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk_rst(1'b0, "R11");
    end
    rd(1'b0, 8'h40, "R11");

    // R8: break disabled has no effect
    @(negedge clk); brk = 1'b1;
    idle(4); brk = 1'b0;
    idle(3);
    chk_rst(1'b0, "R8");
    rd(1'b0, 8'h40, "R8");

    // R8 / R12: enabled break, synchronizer latency
    @(negedge clk); brk_en = 1'b1; brk = 1'b1;
    @(negedge clk); brk = 1'b0;
    chk_rst(1'b0, "R12");
    @(negedge clk); chk_rst(1'b0, "R12");
    @(negedge clk); chk_rst(1'b1, "R12");
    idle(18);
    chk_rst(1'b0, "R3");
    rd(1'b0, 8'h48, "R8");
    brk_en = 1'b0;

    // R7: pin disabled then enabled
    @(negedge clk); ext = 1'b1;
    idle(4); ext = 1'b0;
    idle(3);
    chk_rst(1'b0, "R7");
    rd(1'b0, 8'h48, "R7");
    @(negedge clk); ext_en = 1'b1; ext = 1'b1;
    @(negedge clk); ext = 1'b0;
    idle(2);
    chk_rst(1'b1, "R7");
    idle(18);
    rd(1'b0, 8'h49, "R5");

    // R9: software reset
    wr(1'b1, 8'h01);
    chk_rst(1'b1, "R9");
    rd(1'b1, 8'h01, "R9");
    idle(20);
    chk_rst(1'b0, "R9");
    rd(1'b1, 8'h00, "R9");
    rd(1'b0, 8'h4B, "R9");

    // R10: brownout
    @(negedge clk); bod = 1'b1;
    @(negedge clk); bod = 1'b0;
    idle(2);
    chk_rst(1'b1, "R10");
    idle(18);
    rd(1'b0, 8'h6B, "R10");

    // R4: watchdog disabled then enabled
    @(negedge clk); wdt = 1'b1;
    idle(4); wdt = 1'b0;
    idle(3);
    chk_rst(1'b0, "R4");
    rd(1'b0, 8'h6B, "R4");
    @(negedge clk); wdt_en = 1'b1; wdt = 1'b1;
    @(negedge clk); wdt = 1'b0;
    idle(2);
    chk_rst(1'b1, "R4");
    idle(18);
    rd(1'b0, 8'h30, "R4");
    wdt_en = 1'b0;

    // R7: pin held across the end of power-on
    wr(1'b0, 8'h00);
    rd(1'b0, 8'h00, "R6");
    @(negedge clk); por = 1'b1; ext = 1'b1;
    idle(3);
    por = 1'b0;
    idle(5);
    ext = 1'b0;
    idle(22);
    chk_rst(1'b0, "R7");
    rd(1'b0, 8'h31, "R7");

    idle(3);
    chk(exp_q.size() == 0, "R1 pending-reads", exp_q.size(), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule